// File: doc/BRIEF.md
# Video Timing Reference Detector With Write Pointer Clear

This block sits on the write side of a video frame buffer. It examines each 10-bit word accepted into the buffer and looks for the embedded synchronisation sequence that digital video streams carry: three preamble words (all ones, then all zeros twice) followed by a status word. From that status word it extracts the field bit, the vertical-blanking bit and the horizontal-blanking bit, and keeps them on its outputs until the next sequence arrives.

When the selected status bit (field or vertical blanking, chosen by configuration) drops from 1 to 0 between two consecutive sequences, the block issues a single-cycle pulse that resets the buffer's write address to zero. The first pixel of each frame then lands at address zero without any separate sync wiring. The automatic clear can be turned off. An external clear input always reaches the same pulse output.

Top module: `trs_ptr_clear`

## Requirements
- R1: A status word is decoded only when it follows the preamble 3FF, 000, 000 in accepted words. One cycle after that status word is accepted, `trs_found` is high, and it stays high for exactly one cycle.
- R2: On decode, `f_bit`, `v_bit` and `h_bit` take bits 8, 7 and 6 of the status word. They keep those values until the next decoded status word.
- R3: With `auto_clr_en` high, `ptr_clr` is high in the same cycle as `trs_found` when the selected bit changed from 1 to 0 against the previous decode. `sel_vblank` = 1 selects the vertical-blanking bit. `sel_vblank` = 0 selects the field bit.
- R4: A decode does not pulse `ptr_clr` when the selected bit stays 1, stays 0 or rises. A change of the bit that is not selected has no effect. The pulse lasts one cycle.
- R5: With `auto_clr_en` low, no decode drives `ptr_clr`, and F/V/H decoding continues.
- R6: `ptr_clr` is high in every cycle that follows a cycle with `ext_clr` high. This holds regardless of `wr_en` and of the configuration.
- R7: A word presented while `wr_en` is low is ignored, and the detector's match progress is held.
- R8: An accepted word that breaks a partial preamble returns the detector to idle. A 3FF word always counts as a new first preamble word.
- R9: Synchronous reset clears `trs_found`, `ptr_clr`, F/V/H and any partial match. The first decode after reset therefore compares against F = V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Word on `data_in` is accepted this cycle |
| data_in | input | 10 | Incoming video word |
| auto_clr_en | input | 1 | Enables the automatic pointer clear |
| sel_vblank | input | 1 | 1: vertical-blanking bit triggers the clear; 0: field bit does |
| ext_clr | input | 1 | External pointer clear request |
| f_bit | output | 1 | Latched field bit |
| v_bit | output | 1 | Latched vertical-blanking bit |
| h_bit | output | 1 | Latched horizontal-blanking bit |
| trs_found | output | 1 | One-cycle strobe after a status word is decoded |
| ptr_clr | output | 1 | One-cycle write pointer clear pulse |

## Verification
The hardest case to reach from the ports is a preamble whose progress is interrupted. This happens when `wr_en` drops inside a preamble, when a foreign word breaks it, or when a fresh 3FF restarts it. In each case the detector's state can only be seen through whether a later status word is decoded. The stimulus builds these streams deliberately. The word held during the disabled cycle is 000, so a detector that wrongly accepted it would decode a false status word one word early. Reset is also applied in the middle of a full preamble, after latching non-zero F/V/H. A following status word must then produce no strobe.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Preamble matching progress
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE1 = 2'd1,   // seen all-ones word
        ST_PRE2 = 2'd2,   // seen first all-zeros word
        ST_PRE3 = 2'd3    // seen second all-zeros word; next word is status
    } det_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } sync_bits_t;

    // Choose which status bit drives the automatic clear
    function automatic logic pick_bit(input sync_bits_t b, input logic use_v);
        return use_v ? b.v : b.f;
    endfunction

endpackage

// File: rtl/trs_seq_detect.sv
module trs_seq_detect
    import trs_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] data_in,
    output logic              status_hit
);

    det_state_t state_q, state_d;
    logic       is_ones, is_zero;

    assign is_ones = (data_in == {DATA_W{1'b1}});
    assign is_zero = (data_in == {DATA_W{1'b0}});

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (state_q)
                ST_IDLE: state_d = is_ones ? ST_PRE1 : ST_IDLE;
                ST_PRE1: state_d = is_zero ? ST_PRE2 : (is_ones ? ST_PRE1 : ST_IDLE);
                ST_PRE2: state_d = is_zero ? ST_PRE3 : (is_ones ? ST_PRE1 : ST_IDLE);
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign status_hit = wr_en && (state_q == ST_PRE3);

    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |-> $stable(state_q) || $past(wr_en)); // R7

    AST_HOLD_NEXT: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (state_q == $past(state_q))); // R7

    AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_ones && !is_zero && (state_q != ST_PRE3)) |=> (state_q == ST_IDLE)); // R8

    AST_ONES_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_ones && (state_q != ST_PRE3)) |=> (state_q == ST_PRE1)); // R8

endmodule

// File: rtl/trs_status_decode.sv
module trs_status_decode
    import trs_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              status_hit,
    input  logic [DATA_W-1:0] data_in,
    output sync_bits_t        bits_new,
    output sync_bits_t        bits_q,
    output logic              found_q
);

    localparam int unsigned F_POS = DATA_W - 2;
    localparam int unsigned V_POS = DATA_W - 3;
    localparam int unsigned H_POS = DATA_W - 4;

    always_comb begin
        bits_new.f = data_in[F_POS];
        bits_new.v = data_in[V_POS];
        bits_new.h = data_in[H_POS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q  <= '0;
            found_q <= 1'b0;
        end else begin
            found_q <= status_hit;
            if (status_hit) bits_q <= bits_new;
        end
    end

    AST_FOUND_SINGLE: assert property (@(posedge clk) disable iff (rst)
        found_q |=> !found_q); // R1

    AST_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!found_q && !$past(rst)) |-> $stable(bits_q)); // R2

endmodule

// File: rtl/trs_clear_gen.sv
module trs_clear_gen
    import trs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       status_hit,
    input  sync_bits_t bits_new,
    input  sync_bits_t bits_old,
    input  logic       auto_clr_en,
    input  logic       sel_vblank,
    input  logic       ext_clr,
    output logic       auto_q,
    output logic       ptr_clr
);

    logic fall_seen;

    assign fall_seen = pick_bit(bits_old, sel_vblank) && !pick_bit(bits_new, sel_vblank);

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q  <= 1'b0;
            ptr_clr <= 1'b0;
        end else begin
            auto_q  <= status_hit && auto_clr_en && fall_seen;
            ptr_clr <= ext_clr || (status_hit && auto_clr_en && fall_seen);
        end
    end

    AST_AUTO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (auto_q && !$past(rst)) |-> $past(auto_clr_en)); // R5

    AST_EXT_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
        ($past(ext_clr) && !$past(rst)) |-> ptr_clr); // R6

    AST_AUTO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        auto_q |=> !auto_q); // R4

endmodule

// File: rtl/trs_ptr_clear.sv
module trs_ptr_clear
    import trs_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic              auto_clr_en,
    input  logic              sel_vblank,
    input  logic              ext_clr,
    output logic              f_bit,
    output logic              v_bit,
    output logic              h_bit,
    output logic              trs_found,
    output logic              ptr_clr
);

    logic       status_hit;
    logic       auto_q;
    sync_bits_t bits_new;
    sync_bits_t bits_q;

    trs_seq_detect #(.DATA_W(DATA_W)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .data_in    (data_in),
        .status_hit (status_hit)
    );

    trs_status_decode #(.DATA_W(DATA_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .status_hit (status_hit),
        .data_in    (data_in),
        .bits_new   (bits_new),
        .bits_q     (bits_q),
        .found_q    (trs_found)
    );

    trs_clear_gen u_clear (
        .clk         (clk),
        .rst         (rst),
        .status_hit  (status_hit),
        .bits_new    (bits_new),
        .bits_old    (bits_q),
        .auto_clr_en (auto_clr_en),
        .sel_vblank  (sel_vblank),
        .ext_clr     (ext_clr),
        .auto_q      (auto_q),
        .ptr_clr     (ptr_clr)
    );

    assign f_bit = bits_q.f;
    assign v_bit = bits_q.v;
    assign h_bit = bits_q.h;

    AST_AUTO_WITH_FOUND: assert property (@(posedge clk) disable iff (rst)
        auto_q |-> (trs_found && ptr_clr)); // R3

endmodule

// File: tb/tb_trs_ptr_clear.sv
module tb_trs_ptr_clear;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [9:0] data_in;
    logic       auto_clr_en, sel_vblank, ext_clr;
    logic       f_bit, v_bit, h_bit, trs_found, ptr_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trs_ptr_clear dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .data_in(data_in),
        .auto_clr_en(auto_clr_en), .sel_vblank(sel_vblank), .ext_clr(ext_clr),
        .f_bit(f_bit), .v_bit(v_bit), .h_bit(h_bit),
        .trs_found(trs_found), .ptr_clr(ptr_clr)
    );

    // cfg = {auto_clr_en, sel_vblank, ext_clr}; expect = {found, clr, f, v, h}
    typedef struct packed {
        logic       en;
        logic [9:0] data;
        logic [2:0] cfg;
        logic [4:0] expect_o;
    } vec_t;

    localparam int NVEC = 51;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 10'h3FF, 3'b110, 5'b00000},
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h280, 3'b110, 5'b10010},   // R1 R2: V rises, no clear
        '{1'b1, 10'h155, 3'b110, 5'b00010},
        '{1'b1, 10'h3FF, 3'b110, 5'b00010},
        '{1'b1, 10'h000, 3'b110, 5'b00010},
        '{1'b1, 10'h000, 3'b110, 5'b00010},
        '{1'b1, 10'h200, 3'b110, 5'b11000},   // R3: V falls -> clear
        '{1'b1, 10'h3FF, 3'b110, 5'b00000},   // R4: pulse one cycle
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h200, 3'b110, 5'b10000},   // R4: V stays 0
        '{1'b1, 10'h3FF, 3'b110, 5'b00000},
        '{1'b0, 10'h000, 3'b110, 5'b00000},   // R7: ignored word
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h000, 3'b110, 5'b00000},
        '{1'b1, 10'h240, 3'b110, 5'b10001},   // R7: decode after gap
        '{1'b1, 10'h3FF, 3'b110, 5'b00001},
        '{1'b1, 10'h000, 3'b110, 5'b00001},
        '{1'b1, 10'h155, 3'b110, 5'b00001},   // R8: break
        '{1'b1, 10'h000, 3'b110, 5'b00001},
        '{1'b1, 10'h280, 3'b110, 5'b00001},   // R8: no decode
        '{1'b1, 10'h3FF, 3'b110, 5'b00001},
        '{1'b1, 10'h000, 3'b110, 5'b00001},
        '{1'b1, 10'h3FF, 3'b110, 5'b00001},   // R8: restart
        '{1'b1, 10'h000, 3'b110, 5'b00001},
        '{1'b1, 10'h000, 3'b110, 5'b00001},
        '{1'b1, 10'h280, 3'b110, 5'b10010},   // R8: decode after restart
        '{1'b1, 10'h3FF, 3'b100, 5'b00010},
        '{1'b1, 10'h000, 3'b100, 5'b00010},
        '{1'b1, 10'h000, 3'b100, 5'b00010},
        '{1'b1, 10'h380, 3'b100, 5'b10110},   // R4: F rises
        '{1'b1, 10'h3FF, 3'b100, 5'b00110},
        '{1'b1, 10'h000, 3'b100, 5'b00110},
        '{1'b1, 10'h000, 3'b100, 5'b00110},
        '{1'b1, 10'h300, 3'b100, 5'b10100},   // R4: V falls, not selected
        '{1'b1, 10'h3FF, 3'b100, 5'b00100},
        '{1'b1, 10'h000, 3'b100, 5'b00100},
        '{1'b1, 10'h000, 3'b100, 5'b00100},
        '{1'b1, 10'h200, 3'b100, 5'b11000},   // R3: F falls -> clear
        '{1'b1, 10'h3FF, 3'b010, 5'b00000},
        '{1'b1, 10'h000, 3'b010, 5'b00000},
        '{1'b1, 10'h000, 3'b010, 5'b00000},
        '{1'b1, 10'h280, 3'b010, 5'b10010},
        '{1'b1, 10'h3FF, 3'b010, 5'b00010},
        '{1'b1, 10'h000, 3'b010, 5'b00010},
        '{1'b1, 10'h000, 3'b010, 5'b00010},
        '{1'b1, 10'h200, 3'b010, 5'b10000},   // R5: auto off, no clear
        '{1'b0, 10'h000, 3'b011, 5'b01000},   // R6: external clear
        '{1'b0, 10'h000, 3'b010, 5'b00000}
    };

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b (found,clr,f,v,h)", req, got, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {trs_found, ptr_clr, f_bit, v_bit, h_bit};
    endfunction

    task automatic drive(input logic en, input logic [9:0] d, input logic [2:0] cfg);
        wr_en = en;
        data_in = d;
        {auto_clr_en, sel_vblank, ext_clr} = cfg;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 10'h000, 3'b110);
        repeat (3) @(negedge clk);
        check("R9 reset state", outs(), 5'b00000);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].en, VEC[i].data, VEC[i].cfg);
            @(negedge clk);
            check($sformatf("R1-table row %0d", i), outs(), VEC[i].expect_o);
        end

        // R6: held external clear gives a pulse per cycle
        drive(1'b0, 10'h000, 3'b001);
        @(negedge clk);
        check("R6 ext cycle 1", outs(), 5'b01000);
        @(negedge clk);
        check("R6 ext cycle 2", outs(), 5'b01000);
        drive(1'b0, 10'h000, 3'b110);
        @(negedge clk);
        check("R6 ext released", outs(), 5'b00000);

        // R2: latch non-zero F/V/H
        drive(1'b1, 10'h3FF, 3'b110); @(negedge clk);
        drive(1'b1, 10'h000, 3'b110); @(negedge clk);
        drive(1'b1, 10'h000, 3'b110); @(negedge clk);
        drive(1'b1, 10'h2C0, 3'b110); @(negedge clk);
        check("R2 V and H latched", outs(), 5'b10011);

        // R9: reset in the middle of a complete preamble
        drive(1'b1, 10'h3FF, 3'b110); @(negedge clk);
        drive(1'b1, 10'h000, 3'b110); @(negedge clk);
        drive(1'b1, 10'h000, 3'b110); @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 10'h000, 3'b110);
        @(negedge clk);
        check("R9 reset clears bits", outs(), 5'b00000);
        rst = 1'b0;
        drive(1'b1, 10'h280, 3'b110); @(negedge clk);
        check("R9 no decode after reset", outs(), 5'b00000);
        drive(1'b0, 10'h000, 3'b110); @(negedge clk);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule